// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block keeps a two-stage instruction prefetch queue filled for a 16-bit processor. A holding slot receives fetched words. An execute slot presents the current instruction to the execution unit. An operand register captures the word that may serve as that instruction's immediate operand. The block owns the instruction counter and requests fetches from a bus controller over a request/acknowledge handshake. A slow memory therefore only stalls the queue and cannot corrupt it.

When the execute slot is empty and the holding slot holds an instruction, a completed fetch moves the held instruction forward. The returned word goes into both the holding slot and the operand register. If the advanced instruction needs an immediate operand, the held word is tagged as an operand. The block then fetches again at once, and that result replaces only the held word. If the held word is an instruction while the execute slot is busy, the next fetch waits until the execution unit retires the current instruction.

Jumps, branches, interrupt entry and hold recovery all use a single flush input with a target address. The flush empties the queue, and the queue is then refilled by two back-to-back fetches from the target.

Top module: `ipq_ctrl`

## Requirements
- R1: While reset is high, at the next clock edge `ib_valid_o` becomes 0, `fetch_req_o` becomes 1 and `fetch_addr_o` becomes `RESET_ADDR` (default 0).
- R2: A fetch is accepted in a cycle with `fetch_req_o`=1, `fetch_ack_i`=1 and `flush_i`=0. Each accepted fetch raises `fetch_addr_o` by exactly one in the next cycle, wrapping modulo 2^ADDR_W. No other event changes the address except a flush.
- R3: A fetch accepted while the queue is empty fills only the holding slot, so `ib_valid_o` stays 0 afterwards.
- R4: A fetch accepted while the holding slot is full and the execute slot is empty moves the held word to `ib_o` and stores the new word as the held word and in `di_o`. `ib_valid_o` rises only in the cycle after such an accepted fetch.
- R5: An instruction needs an immediate operand when bit `IMM_BIT` (default 15) of the word is 1. `ib_imm_o` equals 1 exactly when `ib_valid_o` is 1 and that bit of `ib_o` is 1. In that case `di_o` holds the word fetched right after the instruction.
- R6: While the held word is tagged as an operand, `fetch_req_o` is 1. An accepted fetch then replaces only the held word, and `ib_o` and `di_o` keep their values.
- R7: While the held word is an instruction and the execute slot is valid, `fetch_req_o` is 0 until `adv_i` retires the execute slot.
- R8: `adv_i` with `ib_valid_o`=1 clears `ib_valid_o` in the next cycle. If the held word was an operand and no fetch was accepted in that cycle, the operand is dropped as well. `adv_i` with `ib_valid_o`=0 has no effect.
- R9: `flush_i` invalidates both slots and loads `target_i` into the counter, so in the next cycle `ib_valid_o`=0, `fetch_req_o`=1 and `fetch_addr_o`=`target_i`. A word acknowledged in the flush cycle is discarded.
- R10: While `fetch_req_o`=1 and `fetch_ack_i`=0 (no flush), `fetch_req_o` stays 1 and `fetch_addr_o` keeps its value.
- R11: `ib_o` reads as zero whenever `ib_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Redirect: jump, branch, interrupt or hold refill |
| target_i | input | ADDR_W | New fetch address loaded on flush |
| adv_i | input | 1 | Execution unit has finished with the execute slot |
| fetch_req_o | output | 1 | Fetch request to the bus controller |
| fetch_addr_o | output | ADDR_W | Fetch address (instruction counter) |
| fetch_ack_i | input | 1 | Bus controller completes the fetch this cycle |
| fetch_data_i | input | 16 | Fetched word, valid with `fetch_ack_i` |
| ib_valid_o | output | 1 | Execute slot holds an instruction |
| ib_o | output | 16 | Instruction in the execute slot (zero when invalid) |
| ib_imm_o | output | 1 | Execute-slot instruction needs an immediate operand |
| di_o | output | 16 | Operand register |

## Verification
The hardest case to reach is a retire that lands in the same cycle as a fetch completing while the held word is an operand. The new word must survive as an instruction while both the execute slot and the operand are discarded. A retire with no completion in that state must instead empty the queue. The directed phase walks the queue through each fill state with fixed immediate-flag patterns. A long random phase then drives independent acknowledge, retire and flush streams with random words whose immediate bit is set about half the time. This makes operand-tagged holding states common and lets retire and completion collide often.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    // Holding slot: fetched word plus its instruction/operand tag
    typedef struct packed {
        logic  valid;
        logic  is_op;
        word_t word;
    } hold_slot_t;

    // Execute slot
    typedef struct packed {
        logic  valid;
        word_t word;
    } exec_slot_t;

    // Fill state of the queue as seen by the fetch logic
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,   // nothing held
        Q_ONE   = 2'd1,   // holding slot has an instruction, execute slot empty
        Q_OPND  = 2'd2,   // holding slot has the operand of the execute slot
        Q_FULL  = 2'd3    // holding slot has an instruction, execute slot busy
    } fill_e;

    function automatic logic needs_operand(input word_t w, input int unsigned bitpos);
        return w[bitpos];
    endfunction

    function automatic fill_e classify(input hold_slot_t h, input exec_slot_t e);
        if (!h.valid)      return Q_EMPTY;
        else if (!e.valid) return Q_ONE;
        else if (h.is_op)  return Q_OPND;
        else               return Q_FULL;
    endfunction

endpackage

// File: rtl/ipq_counter.sv
module ipq_counter #(
    parameter int ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= RESET_ADDR;
        else if (load_i)  cnt_q <= load_val_i;
        else if (step_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign addr_o = cnt_q;

    // R2: every accepted fetch moves the address by one
    assert_ic_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

endmodule

// File: rtl/ipq_stages.sv
module ipq_stages
    import ipq_pkg::*;
#(
    parameter int unsigned IMM_BIT = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush_i,
    input  logic       accept_i,
    input  word_t      word_i,
    input  logic       adv_i,
    output fill_e      fill_o,
    output exec_slot_t exec_o,
    output word_t      di_o
);
    hold_slot_t hold_q;
    exec_slot_t exec_q;
    word_t      di_q;
    fill_e      fill;
    logic       retire;

    assign fill   = classify(hold_q, exec_q);
    assign retire = adv_i && exec_q.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            exec_q <= '0;
            di_q   <= '0;
        end else if (flush_i) begin
            hold_q.valid <= 1'b0;
            exec_q.valid <= 1'b0;
        end else begin
            unique case (fill)
                Q_EMPTY: begin
                    if (accept_i)
                        hold_q <= '{valid: 1'b1, is_op: 1'b0, word: word_i};
                end
                Q_ONE: begin
                    if (accept_i) begin
                        exec_q <= '{valid: 1'b1, word: hold_q.word};
                        hold_q <= '{valid: 1'b1,
                                    is_op: needs_operand(hold_q.word, IMM_BIT),
                                    word:  word_i};
                        di_q   <= word_i;
                    end
                end
                Q_OPND: begin
                    if (accept_i)
                        hold_q <= '{valid: 1'b1, is_op: 1'b0, word: word_i};
                    if (retire) begin
                        exec_q.valid <= 1'b0;
                        if (!accept_i) hold_q.valid <= 1'b0;
                    end
                end
                Q_FULL: begin
                    if (retire) exec_q.valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign fill_o = fill;
    assign exec_o = exec_q;
    assign di_o   = di_q;

    // R6: an operand-slot refill leaves the execute slot and operand untouched
    assert_opnd_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (fill == Q_OPND && accept_i && !adv_i && !flush_i)
        |=> (exec_q.valid && exec_q.word == $past(exec_q.word) && di_q == $past(di_q)));

endmodule

// File: rtl/ipq_ctrl.sv
module ipq_ctrl
    import ipq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int unsigned IMM_BIT = 15,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              adv_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_ack_i,
    input  logic [15:0]       fetch_data_i,
    output logic              ib_valid_o,
    output logic [15:0]       ib_o,
    output logic              ib_imm_o,
    output logic [15:0]       di_o
);
    fill_e      fill;
    exec_slot_t exec_s;
    word_t      di_s;
    logic       accept;

    assign fetch_req_o = (fill != Q_FULL);
    assign accept      = fetch_req_o && fetch_ack_i && !flush_i;

    ipq_counter #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .load_i     (flush_i),
        .load_val_i (target_i),
        .step_i     (accept),
        .addr_o     (fetch_addr_o)
    );

    ipq_stages #(
        .IMM_BIT (IMM_BIT)
    ) u_stages (
        .clk      (clk),
        .rst      (rst),
        .flush_i  (flush_i),
        .accept_i (accept),
        .word_i   (fetch_data_i),
        .adv_i    (adv_i),
        .fill_o   (fill),
        .exec_o   (exec_s),
        .di_o     (di_s)
    );

    assign ib_valid_o = exec_s.valid;
    assign ib_o       = exec_s.valid ? exec_s.word : '0;
    assign ib_imm_o   = exec_s.valid && needs_operand(exec_s.word, IMM_BIT);
    assign di_o       = di_s;

    // R10: a waiting request holds its address
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && !fetch_ack_i && !flush_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

    // R9: flush redirects and empties the queue
    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!ib_valid_o && fetch_req_o && fetch_addr_o == $past(target_i)));

    // R7: a deferred fetch stays deferred until a retire or flush
    assert_defer_R7: assert property (@(posedge clk) disable iff (rst)
        (ib_valid_o && !fetch_req_o && !adv_i && !flush_i) |=> !fetch_req_o);

    // R4: the execute slot only becomes valid after a completed fetch
    assert_ib_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ib_valid_o) |-> $past(fetch_ack_i && fetch_req_o && !flush_i));

endmodule

// File: tb/ipq_ctrl_tb_top.sv
module ipq_ctrl_tb_top;
    localparam int CLK_P   = 10;
    localparam int IMMB    = 15;
    localparam int N_RAND  = 4000;
    localparam int WDOG    = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic [15:0] target_i = '0;
    logic        adv_i = 1'b0;
    logic        fetch_req_o;
    logic [15:0] fetch_addr_o;
    logic        fetch_ack_i = 1'b0;
    logic [15:0] fetch_data_i = '0;
    logic        ib_valid_o;
    logic [15:0] ib_o;
    logic        ib_imm_o;
    logic [15:0] di_o;

    always #(CLK_P/2) clk = ~clk;

    ipq_ctrl dut_i (
        .clk (clk), .rst (rst), .flush_i (flush_i), .target_i (target_i),
        .adv_i (adv_i), .fetch_req_o (fetch_req_o), .fetch_addr_o (fetch_addr_o),
        .fetch_ack_i (fetch_ack_i), .fetch_data_i (fetch_data_i),
        .ib_valid_o (ib_valid_o), .ib_o (ib_o), .ib_imm_o (ib_imm_o), .di_o (di_o)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    // Reference model: a queue of held words {operand tag, word}, an execute word and a counter
    logic [16:0] held[$];
    bit          m_exv;
    logic [15:0] m_ex;
    logic [15:0] m_di;
    logic [15:0] m_pc;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_req();
        return (held.size() == 0) || !m_exv || held[0][16];
    endfunction

    task automatic compare_all();
        chk("R7 fetch_req_o", 16'(fetch_req_o), 16'(m_req()));
        chk("R2 fetch_addr_o", fetch_addr_o, m_pc);
        chk("R4 ib_valid_o", 16'(ib_valid_o), 16'(m_exv));
        chk("R11 ib_o", ib_o, m_exv ? m_ex : 16'h0);
        chk("R5 ib_imm_o", 16'(ib_imm_o), 16'(m_exv && m_ex[IMMB]));
        if (m_exv && m_ex[IMMB]) chk("R6 di_o", di_o, m_di);
    endtask

    task automatic model_step(input bit a, input logic [15:0] d, input bit v,
                              input bit f, input logic [15:0] t);
        bit acc, ret, was_op;
        if (f) begin
            held.delete();
            m_exv = 0;
            m_pc  = t;
            return;
        end
        acc    = m_req() && a;
        ret    = v && m_exv;
        was_op = (held.size() != 0) && held[0][16];
        if (acc) begin
            m_pc = m_pc + 16'd1;
            if (held.size() == 0) held.push_back({1'b0, d});
            else if (!m_exv) begin
                m_ex    = held[0][15:0];
                m_exv   = 1;
                m_di    = d;
                held[0] = {m_ex[IMMB], d};
            end else if (was_op) held[0] = {1'b0, d};
        end
        if (ret) begin
            m_exv = 0;
            if (was_op && !acc) held.delete();
        end
    endtask

    // Called at a falling edge: check, drive the next inputs, advance the model
    task automatic step(input bit a, input logic [15:0] d, input bit v,
                        input bit f, input logic [15:0] t);
        compare_all();
        fetch_ack_i  = a;
        fetch_data_i = d;
        adv_i        = v;
        flush_i      = f;
        target_i     = t;
        model_step(a, d, v, f, t);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 ib_valid_o", 16'(ib_valid_o), 16'h0);
        chk("R1 fetch_req_o", 16'(fetch_req_o), 16'h1);
        chk("R1 fetch_addr_o", fetch_addr_o, 16'h0000);
        rst = 1'b0;
        held.delete();
        m_exv = 0; m_ex = '0; m_di = '0; m_pc = '0;

        // R10: stall without acknowledge
        step(0, 16'h0, 0, 0, 16'h0);
        chk("R10 fetch_req_o", 16'(fetch_req_o), 16'h1);
        chk("R10 fetch_addr_o", fetch_addr_o, 16'h0000);
        // R3: first fetch fills only the holding slot
        step(1, 16'h0001, 0, 0, 16'h0);
        chk("R3 ib_valid_o", 16'(ib_valid_o), 16'h0);
        chk("R2 fetch_addr_o", fetch_addr_o, 16'h0001);
        // R4: second fetch advances
        step(1, 16'h8002, 0, 0, 16'h0);
        chk("R4 ib_o", ib_o, 16'h0001);
        chk("R4 ib_imm_o", 16'(ib_imm_o), 16'h0);
        chk("R7 fetch_req_o low", 16'(fetch_req_o), 16'h0);
        step(1, 16'h7777, 0, 0, 16'h0);
        chk("R7 still deferred", 16'(fetch_req_o), 16'h0);
        chk("R7 addr unchanged", fetch_addr_o, 16'h0002);
        // R8: retire
        step(0, 16'h0, 1, 0, 16'h0);
        chk("R8 ib_valid_o", 16'(ib_valid_o), 16'h0);
        // R5: instruction needing an operand
        step(1, 16'h1234, 0, 0, 16'h0);
        chk("R5 ib_imm_o", 16'(ib_imm_o), 16'h1);
        chk("R5 di_o", di_o, 16'h1234);
        chk("R6 fetch_req_o", 16'(fetch_req_o), 16'h1);
        // R6: operand-slot refill
        step(1, 16'h0055, 0, 0, 16'h0);
        chk("R6 ib_o", ib_o, 16'h8002);
        chk("R6 di_o", di_o, 16'h1234);
        step(0, 16'h0, 1, 0, 16'h0);
        // R9: flush with a simultaneous acknowledge
        step(1, 16'hFFFF, 0, 1, 16'h0100);
        chk("R9 ib_valid_o", 16'(ib_valid_o), 16'h0);
        chk("R9 fetch_addr_o", fetch_addr_o, 16'h0100);
        chk("R9 fetch_req_o", 16'(fetch_req_o), 16'h1);
        // R8: retire with empty execute slot is ignored
        step(0, 16'h0, 1, 0, 16'h0);
        chk("R8 ignored ib_valid_o", 16'(ib_valid_o), 16'h0);
        chk("R8 ignored fetch_addr_o", fetch_addr_o, 16'h0100);

        for (int i = 0; i < N_RAND; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            step(($urandom % 10) < 6, w, ($urandom % 10) < 3,
                 ($urandom % 100) < 3, 16'($urandom));
        end
        compare_all();

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule